// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Output Stages

This block is a synchronous true dual-port memory model. Two ports, A and B, share one clock, and each port can read or write any word. Each port's read path starts with a latched stage, which is loaded on every enabled clock edge. Each port can then add an output register after that stage. Per-port parameters choose four things:

- whether a write also shows the new word at that port's output, or leaves the output unchanged;
- whether the port presents the latched stage directly or the extra register;
- whether the register's reset or its clock enable wins when both are active;
- the constant that either reset loads.

The two ports can collide on one address. Two reads of the same word both return good data. When one port writes a word that the other port reads in the same cycle, the write completes. The reading port's result for that cycle is invalid, and its collision flag pulses. When both ports write one word in the same cycle, that word becomes unknown. A sticky per-word marker is then set, and any later read of the word is tagged as bad. A later clean write to the word clears the marker.

Top module: `dual_port_ram`

## Requirements
- R1: While a port's enable is low, its latched stage keeps its value whatever its write enable and latch reset are, and the port writes nothing to memory.
- R2: With the port enabled and latch reset high, the latched stage loads that port's set/reset constant. If write enable is also high, the memory write still takes place.
- R3: With the port enabled, latch reset low and write enable low, the latched stage takes the memory word at the port address as it stood before that edge. Every address, from 0 to 2^ADDR_W-1, is reachable.
- R4: In write-first mode, a write stores the data in memory and the latched stage shows the written data after the same edge.
- R5: In no-change mode, a write stores the data in memory and the latched stage keeps its previous value.
- R6: In registered mode with reset priority, an active register reset loads the set/reset constant whatever the clock enable is. Otherwise, enable high copies the latched stage and enable low holds.
- R7: In registered mode with enable priority, enable low holds the register even when reset is high. With enable high, reset high loads the set/reset constant and reset low copies the latched stage.
- R8: In latched mode the port output is the latched stage itself. In registered mode the port output is the register, so it lags the latched stage by one edge.
- R9: Both ports reading the same address in the same cycle each receive the stored word, and neither collision flag rises.
- R10: When a port reads an address that the other port writes in the same cycle, the write completes but the reader's latched data is invalid (all-X). The reader's collision flag is 1 for exactly the following cycle, and a later read with no collision returns the written word.
- R11: When both ports write the same address in one cycle, that word becomes all-X and its sticky marker is set. A port that later reads the word raises its bad flag, which travels with the latched stage. A later single-port write to the word stores good data and clears the marker.
- R12: After reset, every memory word is zero, every latched stage and output register holds its port's set/reset constant, and the collision and bad flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the initial state |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_lrst | input | 1 | Port A latched-stage reset |
| a_rce | input | 1 | Port A output-register clock enable |
| a_rrst | input | 1 | Port A output-register reset |
| a_addr | input | ADDR_W | Port A word address |
| a_din | input | DATA_W | Port A write data |
| a_dout | output | DATA_W | Port A read data |
| a_coll | output | 1 | Port A read was invalidated by a port B write |
| a_bad | output | 1 | Port A latched word came from a corrupted location |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_lrst | input | 1 | Port B latched-stage reset |
| b_rce | input | 1 | Port B output-register clock enable |
| b_rrst | input | 1 | Port B output-register reset |
| b_addr | input | ADDR_W | Port B word address |
| b_din | input | DATA_W | Port B write data |
| b_dout | output | DATA_W | Port B read data |
| b_coll | output | 1 | Port B read was invalidated by a port A write |
| b_bad | output | 1 | Port B latched word came from a corrupted location |

## Verification
The hardest situation to reach from the ports is the life of a corrupted word. It needs a same-cycle write-write clash, then a later read that carries the bad tag, then a clean rewrite that clears the tag, then a read from the other port. The stimulus sets this up as four consecutive operations on one address.

The bench also drives the same operations into a second instance built with latched outputs. Every cycle it compares both the registered and the latched view against one reference model. The priority rows can then be checked as register values that differ visibly from the latched value.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
   typedef enum logic {WR_FIRST, WR_KEEP}      wr_mode_e;
   typedef enum logic {OUT_LATCH, OUT_REG}     out_mode_e;
   typedef enum logic {PRI_RESET, PRI_ENABLE}  reg_pri_e;
endpackage

// File: rtl/dpram_collide.sv
module dpram_collide #(
   parameter int ADDR_W = 8
) (
   input  logic              a_wr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              a_hit,
   output logic              b_hit,
   output logic              both_wr
);
   logic same_addr;

   assign same_addr = (a_addr == b_addr);
   // a port is "hit" when the opposite port writes the word it addresses
   assign a_hit     = b_wr & same_addr;
   assign b_hit     = a_wr & same_addr;
   assign both_wr   = a_wr & b_wr & same_addr;
endmodule

// File: rtl/dpram_array.sv
module dpram_array #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_wr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_din,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_din,
   input  logic              both_wr,
   output logic [DATA_W-1:0] a_rdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              a_rbad,
   output logic              b_rbad
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0]  bad_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         bad_bits <= '0;
      end else if (both_wr) begin
         mem[a_addr]      <= 'x;
         bad_bits[a_addr] <= 1'b1;
      end else begin
         if (a_wr) begin
            mem[a_addr]      <= a_din;
            bad_bits[a_addr] <= 1'b0;
         end
         if (b_wr) begin
            mem[b_addr]      <= b_din;
            bad_bits[b_addr] <= 1'b0;
         end
      end
   end

   assign a_rdata = mem[a_addr];
   assign b_rdata = mem[b_addr];
   assign a_rbad  = bad_bits[a_addr];
   assign b_rbad  = bad_bits[b_addr];

   AST_CLASH_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      both_wr |=> bad_bits[$past(a_addr)]); // R11
   AST_SOLO_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && !b_wr) |=> (mem[$past(a_addr)] == $past(a_din)) && !bad_bits[$past(a_addr)]); // R4
endmodule

// File: rtl/dpram_port_out.sv
module dpram_port_out
   import dpram_pkg::*;
#(
   parameter int                DATA_W = 16,
   parameter wr_mode_e          WMODE  = WR_FIRST,
   parameter out_mode_e         OMODE  = OUT_REG,
   parameter reg_pri_e          PRIO   = PRI_RESET,
   parameter logic [DATA_W-1:0] SRVAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic              lrst,
   input  logic              rce,
   input  logic              rrst,
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-1:0] rdata,
   input  logic              rbad,
   input  logic              other_hit,
   output logic [DATA_W-1:0] dout,
   output logic              coll,
   output logic              bad
);
   logic [DATA_W-1:0] lat_q;
   logic              rd_now;

   if (DATA_W < 1) begin : g_chk_w
      $error("dpram_port_out: DATA_W must be at least 1");
   end

   assign rd_now = en & ~lrst & ~we;

   // latched stage with its bad tag and the collision pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= SRVAL;
         bad   <= 1'b0;
         coll  <= 1'b0;
      end else begin
         coll <= rd_now & other_hit;
         if (en) begin
            if (lrst) begin
               lat_q <= SRVAL;
               bad   <= 1'b0;
            end else if (!we) begin
               lat_q <= other_hit ? {DATA_W{1'bx}} : rdata;
               bad   <= rbad;
            end else if (WMODE == WR_FIRST) begin
               lat_q <= din;
               bad   <= 1'b0;
            end
         end
      end
   end

   if (OMODE == OUT_REG) begin : g_reg
      logic [DATA_W-1:0] reg_q;

      if (PRIO == PRI_RESET) begin : g_rst_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     reg_q <= SRVAL;
            else if (rrst)  reg_q <= SRVAL;
            else if (rce)   reg_q <= lat_q;
         end
         AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            rrst |=> dout == SRVAL); // R6
      end else begin : g_ce_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     reg_q <= SRVAL;
            else if (rce)   reg_q <= rrst ? SRVAL : lat_q;
         end
         AST_CE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
            !rce |=> $stable(dout)); // R7
      end

      assign dout = reg_q;
   end else begin : g_lat
      logic unused_reg_ctl;
      assign unused_reg_ctl = rce ^ rrst;
      assign dout = lat_q;
   end

   AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(lat_q)); // R1
   AST_LRST_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (en && lrst) |=> lat_q == SRVAL); // R2
   AST_COLL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && other_hit) |=> coll); // R10
   AST_COLL_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_now && other_hit) |=> !coll); // R9
endmodule

// File: rtl/dual_port_ram.sv
module dual_port_ram
   import dpram_pkg::*;
#(
   parameter int                DATA_W  = 16,
   parameter int                ADDR_W  = 8,
   parameter wr_mode_e          A_WMODE = WR_FIRST,
   parameter out_mode_e         A_OMODE = OUT_REG,
   parameter reg_pri_e          A_PRIO  = PRI_RESET,
   parameter logic [DATA_W-1:0] A_SRVAL = '0,
   parameter wr_mode_e          B_WMODE = WR_KEEP,
   parameter out_mode_e         B_OMODE = OUT_REG,
   parameter reg_pri_e          B_PRIO  = PRI_ENABLE,
   parameter logic [DATA_W-1:0] B_SRVAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic              a_lrst,
   input  logic              a_rce,
   input  logic              a_rrst,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_din,
   output logic [DATA_W-1:0] a_dout,
   output logic              a_coll,
   output logic              a_bad,
   input  logic              b_en,
   input  logic              b_we,
   input  logic              b_lrst,
   input  logic              b_rce,
   input  logic              b_rrst,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_din,
   output logic [DATA_W-1:0] b_dout,
   output logic              b_coll,
   output logic              b_bad
);
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_chk_a
      $error("dual_port_ram: ADDR_W must lie in 1..16");
   end

   logic              a_wr, b_wr, a_hit, b_hit, both_wr, a_rbad, b_rbad;
   logic [DATA_W-1:0] a_rdata, b_rdata;

   assign a_wr = a_en & a_we;
   assign b_wr = b_en & b_we;

   dpram_collide #(.ADDR_W(ADDR_W)) u_collide (
      .a_wr(a_wr), .a_addr(a_addr), .b_wr(b_wr), .b_addr(b_addr),
      .a_hit(a_hit), .b_hit(b_hit), .both_wr(both_wr)
   );

   dpram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .a_wr(a_wr), .a_addr(a_addr), .a_din(a_din),
      .b_wr(b_wr), .b_addr(b_addr), .b_din(b_din),
      .both_wr(both_wr),
      .a_rdata(a_rdata), .b_rdata(b_rdata), .a_rbad(a_rbad), .b_rbad(b_rbad)
   );

   dpram_port_out #(.DATA_W(DATA_W), .WMODE(A_WMODE), .OMODE(A_OMODE),
                    .PRIO(A_PRIO), .SRVAL(A_SRVAL)) u_out_a (
      .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we), .lrst(a_lrst),
      .rce(a_rce), .rrst(a_rrst), .din(a_din), .rdata(a_rdata),
      .rbad(a_rbad), .other_hit(a_hit),
      .dout(a_dout), .coll(a_coll), .bad(a_bad)
   );

   dpram_port_out #(.DATA_W(DATA_W), .WMODE(B_WMODE), .OMODE(B_OMODE),
                    .PRIO(B_PRIO), .SRVAL(B_SRVAL)) u_out_b (
      .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we), .lrst(b_lrst),
      .rce(b_rce), .rrst(b_rrst), .din(b_din), .rdata(b_rdata),
      .rbad(b_rbad), .other_hit(b_hit),
      .dout(b_dout), .coll(b_coll), .bad(b_bad)
   );

   AST_NO_DOUBLE_COLL: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_coll && b_coll)); // R10
endmodule

// File: tb/dual_port_ram_tb.sv
module dual_port_ram_tb;
   import dpram_pkg::*;

   localparam logic [15:0] SRA = 16'hA5A5;
   localparam logic [15:0] SRB = 16'h5A0F;

   typedef struct packed {
      logic       en, we, lr, rce, rrst;
      logic [7:0] addr;
      logic [15:0] din;
   } pin_t;

   typedef struct packed {
      logic [23:0]       tag;
      logic [1:0][15:0]  regv;
      logic [1:0][15:0]  lat;
      logic [1:0]        rok, lok, coll, bad;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   pin_t pa = '0, pb = '0;
   logic [1:0][15:0] r_dout, l_dout;
   logic [1:0]       r_coll, l_coll, r_bad, l_bad;

   dual_port_ram #(.DATA_W(16), .ADDR_W(8),
      .A_WMODE(WR_FIRST), .A_OMODE(OUT_REG), .A_PRIO(PRI_RESET),  .A_SRVAL(SRA),
      .B_WMODE(WR_KEEP),  .B_OMODE(OUT_REG), .B_PRIO(PRI_ENABLE), .B_SRVAL(SRB)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .a_en(pa.en), .a_we(pa.we), .a_lrst(pa.lr), .a_rce(pa.rce), .a_rrst(pa.rrst),
      .a_addr(pa.addr), .a_din(pa.din), .a_dout(r_dout[0]), .a_coll(r_coll[0]), .a_bad(r_bad[0]),
      .b_en(pb.en), .b_we(pb.we), .b_lrst(pb.lr), .b_rce(pb.rce), .b_rrst(pb.rrst),
      .b_addr(pb.addr), .b_din(pb.din), .b_dout(r_dout[1]), .b_coll(r_coll[1]), .b_bad(r_bad[1]));

   dual_port_ram #(.DATA_W(16), .ADDR_W(8),
      .A_WMODE(WR_FIRST), .A_OMODE(OUT_LATCH), .A_PRIO(PRI_RESET),  .A_SRVAL(SRA),
      .B_WMODE(WR_KEEP),  .B_OMODE(OUT_LATCH), .B_PRIO(PRI_ENABLE), .B_SRVAL(SRB)) u_dut_lat (
      .clk(clk), .rst_n(rst_n),
      .a_en(pa.en), .a_we(pa.we), .a_lrst(pa.lr), .a_rce(pa.rce), .a_rrst(pa.rrst),
      .a_addr(pa.addr), .a_din(pa.din), .a_dout(l_dout[0]), .a_coll(l_coll[0]), .a_bad(l_bad[0]),
      .b_en(pb.en), .b_we(pb.we), .b_lrst(pb.lr), .b_rce(pb.rce), .b_rrst(pb.rrst),
      .b_addr(pb.addr), .b_din(pb.din), .b_dout(l_dout[1]), .b_coll(l_coll[1]), .b_bad(l_bad[1]));

   // reference model
   logic [15:0] m_mem [256];
   bit          m_bad [256];
   logic [15:0] m_lat [2], m_reg [2];
   bit          m_lok [2], m_rok [2], m_lbad [2];
   logic [15:0] sr [2];

   int   n_chk = 0, n_fail = 0;
   exp_t q[$];

   function automatic pin_t mk(input logic en, we, lr, rce, rrst,
                               input logic [7:0] addr, input logic [15:0] din);
      pin_t p;
      p.en = en; p.we = we; p.lr = lr; p.rce = rce; p.rrst = rrst;
      p.addr = addr; p.din = din;
      return p;
   endfunction

   // shorthand: read with register passing, write with register passing, idle
   function automatic pin_t rd(input logic [7:0] a);  return mk(1,0,0,1,0,a,16'h0); endfunction
   function automatic pin_t wr(input logic [7:0] a, input logic [15:0] d); return mk(1,1,0,1,0,a,d); endfunction
   function automatic pin_t idle();                   return mk(0,0,0,0,0,8'h0,16'h0); endfunction

   task automatic chk(input logic [23:0] tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: apply one cycle of stimulus, advance the model, push expectation
   task automatic op(input logic [23:0] tag, input pin_t xa, input pin_t xb);
      pin_t pn [2];
      bit   w [2], r [2], hit [2], ww;
      exp_t e;
      @(negedge clk);
      pa = xa; pb = xb;
      pn[0] = xa; pn[1] = xb;
      @(posedge clk);
      #1;
      for (int p = 0; p < 2; p++) begin
         w[p] = pn[p].en && pn[p].we;
         r[p] = pn[p].en && !pn[p].we && !pn[p].lr;
      end
      for (int p = 0; p < 2; p++)
         hit[p] = w[1-p] && (pn[1-p].addr == pn[p].addr);
      ww = w[0] && w[1] && (pn[0].addr == pn[1].addr);
      e = '0;
      e.tag = tag;
      for (int p = 0; p < 2; p++) begin
         // output register, fed by the pre-edge latched value
         if (p == 0) begin
            if (pn[p].rrst) begin m_reg[p] = sr[p]; m_rok[p] = 1; end
            else if (pn[p].rce) begin m_reg[p] = m_lat[p]; m_rok[p] = m_lok[p]; end
         end else if (pn[p].rce) begin
            if (pn[p].rrst) begin m_reg[p] = sr[p]; m_rok[p] = 1; end
            else begin m_reg[p] = m_lat[p]; m_rok[p] = m_lok[p]; end
         end
         e.coll[p] = r[p] && hit[p];
         if (pn[p].en) begin
            if (pn[p].lr) begin
               m_lat[p] = sr[p]; m_lok[p] = 1; m_lbad[p] = 0;
            end else if (!pn[p].we) begin
               m_lbad[p] = m_bad[pn[p].addr];
               if (hit[p]) m_lok[p] = 0;
               else begin m_lat[p] = m_mem[pn[p].addr]; m_lok[p] = !m_bad[pn[p].addr]; end
            end else if (p == 0) begin
               m_lat[p] = pn[p].din; m_lok[p] = 1; m_lbad[p] = 0;
            end
         end
         e.regv[p] = m_reg[p]; e.rok[p] = m_rok[p];
         e.lat[p]  = m_lat[p]; e.lok[p] = m_lok[p];
         e.bad[p]  = m_lbad[p];
      end
      if (ww) m_bad[pn[0].addr] = 1;
      else begin
         for (int p = 0; p < 2; p++)
            if (w[p]) begin m_mem[pn[p].addr] = pn[p].din; m_bad[pn[p].addr] = 0; end
      end
      q.push_back(e);
   endtask

   // monitor: compare both views one half-cycle after each edge
   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         for (int p = 0; p < 2; p++) begin
            if (e.rok[p]) chk(e.tag, p ? "B reg dout" : "A reg dout", r_dout[p], e.regv[p]);
            if (e.lok[p]) chk(e.tag, p ? "B lat dout" : "A lat dout", l_dout[p], e.lat[p]);
            chk(e.tag, p ? "B coll(reg)" : "A coll(reg)", {15'h0, r_coll[p]}, {15'h0, e.coll[p]});
            chk(e.tag, p ? "B coll(lat)" : "A coll(lat)", {15'h0, l_coll[p]}, {15'h0, e.coll[p]});
            chk(e.tag, p ? "B bad(reg)"  : "A bad(reg)",  {15'h0, r_bad[p]},  {15'h0, e.bad[p]});
            chk(e.tag, p ? "B bad(lat)"  : "A bad(lat)",  {15'h0, l_bad[p]},  {15'h0, e.bad[p]});
         end
      end
   end

   bit done = 0;
   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      sr[0] = SRA; sr[1] = SRB;
      for (int i = 0; i < 256; i++) begin m_mem[i] = '0; m_bad[i] = 0; end
      for (int p = 0; p < 2; p++) begin
         m_lat[p] = sr[p]; m_reg[p] = sr[p];
         m_lok[p] = 1; m_rok[p] = 1; m_lbad[p] = 0;
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R12: initial state, and memory reads as zero
      op("R12", idle(), idle());
      op("R12", rd(8'd200), rd(8'd7));
      op("R12", idle(), idle());

      // R4 write-first on A, R5 no-change on B
      op("R4", wr(8'd10, 16'h1234), idle());
      op("R5", idle(), wr(8'd20, 16'hBEEF));
      op("R5", idle(), idle());
      // R3 cross reads
      op("R3", rd(8'd20), rd(8'd10));
      op("R3", idle(), idle());
      // R9 both read the same word
      op("R9", rd(8'd10), rd(8'd10));
      op("R9", idle(), idle());

      // R1 disabled with write and latch reset asserted: no change, no write
      op("R1", mk(0,1,1,1,0,8'd10,16'hFFFF), mk(0,1,1,1,0,8'd20,16'hFFFF));
      op("R1", idle(), idle());
      op("R1", rd(8'd10), rd(8'd20));
      op("R1", idle(), idle());

      // R2 latch reset beats write; the write still lands
      op("R2", mk(1,1,1,1,0,8'd30,16'h7777), mk(1,0,1,1,0,8'd31,16'h0));
      op("R2", idle(), idle());
      op("R2", rd(8'd30), rd(8'd30));
      op("R2", idle(), idle());

      // R6 reset-priority register on A, R7 enable-priority register on B
      op("R6", rd(8'd10), rd(8'd10));
      op("R6", mk(0,0,0,0,1,8'd0,16'h0), mk(0,0,0,0,1,8'd0,16'h0));
      op("R6", mk(0,0,0,1,0,8'd0,16'h0), mk(0,0,0,1,0,8'd0,16'h0));
      op("R7", mk(0,0,0,1,1,8'd0,16'h0), mk(0,0,0,1,1,8'd0,16'h0));
      op("R7", mk(0,0,0,0,0,8'd0,16'h0), mk(0,0,0,0,0,8'd0,16'h0));
      op("R7", mk(0,0,0,1,0,8'd0,16'h0), mk(0,0,0,1,0,8'd0,16'h0));
      // R8 register lags the latched view; enable low freezes it
      op("R8", mk(1,0,0,0,0,8'd20,16'h0), mk(1,0,0,0,0,8'd30,16'h0));
      op("R8", mk(0,0,0,0,0,8'd0,16'h0), mk(0,0,0,0,0,8'd0,16'h0));
      op("R8", mk(0,0,0,1,0,8'd0,16'h0), mk(0,0,0,1,0,8'd0,16'h0));

      // R10 read-write collisions both directions, then clean rereads
      op("R10", wr(8'd40, 16'h4444), rd(8'd40));
      op("R10", rd(8'd41), wr(8'd41, 16'h4141));
      op("R10", rd(8'd40), rd(8'd41));
      op("R10", rd(8'd41), rd(8'd40));
      op("R10", idle(), idle());

      // R11 write-write clash, tagged read, clean rewrite, reread
      op("R11", wr(8'd50, 16'h5050), wr(8'd50, 16'h0505));
      op("R11", rd(8'd50), idle());
      op("R11", idle(), rd(8'd50));
      op("R11", wr(8'd50, 16'h1111), idle());
      op("R11", rd(8'd50), rd(8'd50));
      op("R11", idle(), idle());

      // R3 boundary addresses and a pattern sweep
      op("R3", wr(8'd0, 16'h0F0F), wr(8'd255, 16'hF0F0));
      op("R3", rd(8'd255), rd(8'd0));
      for (int i = 0; i < 16; i++) begin
         op("R3", wr(8'(i * 16 + 1), 16'(i * 16'h1111 ^ 16'h3C5A)),
                  wr(8'(i * 16 + 2), 16'(i * 16'h0101 + 16'h8001)));
      end
      for (int i = 0; i < 16; i++) begin
         op("R3", rd(8'(i * 16 + 2)), rd(8'(i * 16 + 1)));
      end
      op("R3", idle(), idle());
      op("R3", idle(), idle());

      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule